// File: doc/BRIEF.md
# External Register Bus Controller

This block sits between a processor core and a small set of memory-mapped registers that live outside the core. It carries one transfer at a time over a shared bus. That bus has a 16-bit data path with separate in, out and output-enable signals, a 3-bit latched register address, an active-low data strobe, a read/write select and an active-low wait input.

The core raises a request with a register index, a direction, write data and a flag that says whether the target is internal or external. The block then runs the bus cycle. It stretches the cycle by a programmable internal wait state and by the external wait line. At the end it returns read data together with a one-cycle completion pulse.

Index 7 belongs to the processor itself. A user request that names it is refused: the block raises an error pulse and runs no bus cycle. The address is driven for every accepted transfer. The strobe, and the data output enable for writes, are used only when the target is external.

Top module: `xreg_bus_ctrl`

## Requirements
- R1: On acceptance of a request the register index is loaded into `bus_addr` for both internal and external targets, and it stays unchanged until the next accepted request.
- R2: `bus_strobe_n` is low in every transfer cycle of an external transfer and high at all other times, including throughout internal transfers.
- R3: `bus_rnw` is 0 in every cycle of a write transfer and 1 otherwise; while it is 0 and the strobe is low, `bus_dout` carries the request's write data.
- R4: `bus_doe` is 1 only in the transfer cycles of an external write, or whenever `port_out_mode` is 1.
- R5: With no external wait, a transfer lasts 1 cycle, or 1 + INT_WAITS cycles (INT_WAITS = 1 by default) when `cfg_wait` is 1 at acceptance.
- R6: `bus_wait_n` is active low and sampled through one register on each rising edge. During an external transfer, every edge from the acceptance edge onward at which it is sampled low adds one cycle on top of R5. It has no effect on internal transfers.
- R7: A request with index 7 is refused. `rsp_err` pulses for exactly the cycle after the request edge; no transfer starts, `busy` stays 0, the strobe stays high, `bus_addr` is unchanged and `rsp_done` is not raised.
- R8: On the last transfer edge of a read, `bus_din` is captured into `rsp_rdata`, which then holds that value. `rsp_done` is 1 for exactly the one cycle after the last transfer edge of any transfer.
- R9: `busy` is 1 exactly during transfer cycles, and a request is accepted only while `busy` is 0.
- R10: After reset the outputs read `bus_strobe_n`=1, `bus_rnw`=1, `bus_doe`=0, `busy`=0, `rsp_done`=0 and `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Transfer request from the core |
| req_idx | input | 3 | Register index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = external target, 0 = internal |
| req_wdata | input | 16 | Write data |
| cfg_wait | input | 1 | Adds the internal wait state(s) |
| port_out_mode | input | 1 | Shared port configured as output; forces the data enable |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle refusal pulse for the reserved index |
| busy | output | 1 | Transfer in progress; the core stalls |
| bus_addr | output | 3 | Latched register address |
| bus_dout | output | 16 | Data bus output value |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 16 | Data bus input value |
| bus_strobe_n | output | 1 | Active-low data strobe |
| bus_rnw | output | 1 | Read (1) / write (0) select |
| bus_wait_n | input | 1 | Active-low wait from the peripheral |

## Verification
The assertions assume that `bus_wait_n` meets setup and hold at the rising edge, so the single register stage sees a clean level. They also assume that `port_out_mode` is the only other source of the data enable. The bench changes `bus_wait_n`, `bus_din` and every request input only on falling edges. It holds the wait line low for a fixed number of sampling edges that starts at the acceptance edge, so the expected length of each transfer follows directly from R5 and R6.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
  typedef enum logic [0:0] {
    XRB_IDLE = 1'b0,
    XRB_XFER = 1'b1
  } xrb_state_e;
endpackage

// File: rtl/xrb_wait_sync.sv
// Single sampling stage for the active-low external wait line.
module xrb_wait_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n,
  output logic wait_act
);
  logic act_q;
  logic act_d;

  always_comb act_d = ~wait_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign wait_act = act_q;
endmodule

// File: rtl/xrb_seq.sv
// Transfer sequencer: acceptance, reserved-index refusal, wait stretching.
module xrb_seq
  import xrb_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int INT_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_idx,
  input  logic              req_write,
  input  logic              req_ext,
  input  logic              cfg_wait,
  input  logic              wait_act,
  output logic              accept,
  output logic              finish,
  output logic              busy,
  output logic              xfer_ext,
  output logic              xfer_write,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = (INT_WAITS < 1) ? 1 : $clog2(INT_WAITS + 1);
  localparam logic [ADDR_W-1:0] RSV_IDX = '1;

  xrb_state_e       st_q, st_d;
  logic [CNT_W-1:0] stall_q, stall_d;
  logic             ext_q, ext_d, wr_q, wr_d;
  logic             done_q, err_q;
  logic             reject, is_rsv, wait_hit;
  logic [CNT_W:0]   pending, pend_m1;

  always_comb begin
    is_rsv   = (req_idx == RSV_IDX);
    accept   = (st_q == XRB_IDLE) && req_valid && !is_rsv;
    reject   = (st_q == XRB_IDLE) && req_valid && is_rsv;
    wait_hit = ext_q && wait_act;
    pending  = {1'b0, stall_q} + {{CNT_W{1'b0}}, wait_hit};
    pend_m1  = pending - {{CNT_W{1'b0}}, 1'b1};
    finish   = (st_q == XRB_XFER) && (pending == '0);
  end

  always_comb begin
    st_d    = st_q;
    stall_d = stall_q;
    ext_d   = ext_q;
    wr_d    = wr_q;
    case (st_q)
      XRB_IDLE: begin
        if (accept) begin
          st_d    = XRB_XFER;
          stall_d = cfg_wait ? CNT_W'(INT_WAITS) : '0;
          ext_d   = req_ext;
          wr_d    = req_write;
        end
      end
      XRB_XFER: begin
        if (finish) st_d = XRB_IDLE;
        else        stall_d = pend_m1[CNT_W-1:0];
      end
      default: st_d = XRB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XRB_IDLE;
      stall_q <= '0;
      ext_q   <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      stall_q <= stall_d;
      ext_q   <= ext_d;
      wr_q    <= wr_d;
      done_q  <= finish;
      err_q   <= reject;
    end
  end

  assign busy       = (st_q == XRB_XFER);
  assign xfer_ext   = ext_q;
  assign xfer_write = wr_q;
  assign done       = done_q;
  assign err        = err_q;

  // R5: the stall credit never exceeds the programmed internal wait count
  a_r5_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q <= CNT_W'(INT_WAITS));
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: an accepted request starts a transfer on the next cycle
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R7: a refusal never coincides with a running transfer
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy);
endmodule

// File: rtl/xrb_pad.sv
// Bus-side registers and pad control decode.
module xrb_pad #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              finish,
  input  logic              busy,
  input  logic              xfer_ext,
  input  logic              xfer_write,
  input  logic [ADDR_W-1:0] req_idx,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              port_out_mode,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_strobe_n,
  output logic              bus_rnw,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] dout_q, dout_d, rdat_q, rdat_d;
  logic              addr_en, dout_en, rdat_en;

  always_comb begin
    addr_en = accept;
    dout_en = accept && req_write;
    rdat_en = finish && !xfer_write;
    addr_d  = addr_en ? req_idx   : addr_q;
    dout_d  = dout_en ? req_wdata : dout_q;
    rdat_d  = rdat_en ? bus_din   : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dout_q <= '0;
      rdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      dout_q <= dout_d;
      rdat_q <= rdat_d;
    end
  end

  always_comb begin
    bus_strobe_n = !(busy && xfer_ext);
    bus_rnw      = !(busy && xfer_write);
    bus_doe      = (busy && xfer_ext && xfer_write) || port_out_mode;
  end

  assign bus_addr  = addr_q;
  assign bus_dout  = dout_q;
  assign rsp_rdata = rdat_q;

  // R1: the address holds steady across the cycles of one transfer
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
  // R3: a strobed write always has its data driven
  a_r3_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strobe_n && !bus_rnw) |-> bus_doe);
  // R2: the strobe is only active inside a transfer
  a_r2_strobe_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe_n |-> busy);
endmodule

// File: rtl/xreg_bus_ctrl.sv
module xreg_bus_ctrl #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16,
  parameter int INT_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_idx,
  input  logic              req_write,
  input  logic              req_ext,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_wait,
  input  logic              port_out_mode,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_strobe_n,
  output logic              bus_rnw,
  input  logic              bus_wait_n
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       wait_act, accept, finish, xfer_ext, xfer_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  xrb_wait_sync u_wait (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wait_n   (bus_wait_n),
    .wait_act (wait_act)
  );

  xrb_seq #(.ADDR_W(ADDR_W), .INT_WAITS(INT_WAITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_ni),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .req_write  (req_write),
    .req_ext    (req_ext),
    .cfg_wait   (cfg_wait),
    .wait_act   (wait_act),
    .accept     (accept),
    .finish     (finish),
    .busy       (busy),
    .xfer_ext   (xfer_ext),
    .xfer_write (xfer_write),
    .done       (rsp_done),
    .err        (rsp_err)
  );

  xrb_pad #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pad (
    .clk           (clk),
    .rst_n         (rst_ni),
    .accept        (accept),
    .finish        (finish),
    .busy          (busy),
    .xfer_ext      (xfer_ext),
    .xfer_write    (xfer_write),
    .req_idx       (req_idx),
    .req_write     (req_write),
    .req_wdata     (req_wdata),
    .port_out_mode (port_out_mode),
    .bus_din       (bus_din),
    .bus_addr      (bus_addr),
    .bus_dout      (bus_dout),
    .bus_doe       (bus_doe),
    .bus_strobe_n  (bus_strobe_n),
    .bus_rnw       (bus_rnw),
    .rsp_rdata     (rsp_rdata)
  );

  // R4: data enable only for an external write transfer or port output mode
  a_r4_doe_source: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_doe && !port_out_mode) |-> (!bus_strobe_n && !bus_rnw));
  // R7: a refusal leaves the strobe idle
  a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_err |-> bus_strobe_n);
  // R8: done and refusal never coincide
  a_r8_done_not_err: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rsp_done && rsp_err));
endmodule

// File: tb/test_xreg_bus_ctrl.sv
module test_xreg_bus_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ext, cfg_wait, port_out_mode;
  logic [2:0]  req_idx;
  logic [15:0] req_wdata, bus_din;
  logic        bus_wait_n;
  logic [15:0] rsp_rdata, bus_dout;
  logic        rsp_done, rsp_err, busy, bus_doe, bus_strobe_n, bus_rnw;
  logic [2:0]  bus_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xreg_bus_ctrl i_xreg_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_write(req_write), .req_ext(req_ext), .req_wdata(req_wdata),
    .cfg_wait(cfg_wait), .port_out_mode(port_out_mode), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_strobe_n(bus_strobe_n), .bus_rnw(bus_rnw), .bus_wait_n(bus_wait_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one transfer; the wait line is held low for n_wait sampling edges
  // starting at the acceptance edge. Results summarise every transfer cycle.
  task automatic run_xfer(input logic [2:0] idx, input bit wr, input bit ext,
                          input bit wt, input logic [15:0] wd,
                          input logic [15:0] din, input int n_wait,
                          output int dur, output int strobe_cyc,
                          output int doe_cyc, output int rnw_low_cyc,
                          output int bad_addr, output int bad_dout);
    dur = 0; strobe_cyc = 0; doe_cyc = 0; rnw_low_cyc = 0;
    bad_addr = 0; bad_dout = 0;
    @(negedge clk);
    req_valid = 1'b1; req_idx = idx; req_write = wr; req_ext = ext;
    cfg_wait = wt; req_wdata = wd; bus_din = din;
    bus_wait_n = (n_wait > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && dur < 40) begin
      dur++;
      if (!bus_strobe_n) strobe_cyc++;
      if (bus_doe) doe_cyc++;
      if (!bus_rnw) rnw_low_cyc++;
      if (bus_addr != idx) bad_addr++;
      if (!bus_strobe_n && !bus_rnw && bus_dout != wd) bad_dout++;
      if (dur == n_wait) bus_wait_n = 1'b1;
      @(negedge clk);
    end
    bus_wait_n = 1'b1;
  endtask

  task automatic t_reset;
    chk(bus_strobe_n === 1'b1, "R10 strobe", int'(bus_strobe_n), 1);
    chk(bus_rnw === 1'b1, "R10 rnw", int'(bus_rnw), 1);
    chk(bus_doe === 1'b0, "R10 doe", int'(bus_doe), 0);
    chk(busy === 1'b0, "R10 busy", int'(busy), 0);
    chk(rsp_done === 1'b0 && rsp_err === 1'b0, "R10 done/err",
        int'(rsp_done | rsp_err), 0);
  endtask

  task automatic t_ext_write;
    int d, s, o, r, ba, bd;
    run_xfer(3'd5, 1'b1, 1'b1, 1'b0, 16'hA55A, 16'h0, 0, d, s, o, r, ba, bd);
    chk(d == 1, "R5 ext write length", d, 1);
    chk(s == 1, "R2 ext write strobe", s, 1);
    chk(o == 1, "R4 ext write doe", o, 1);
    chk(r == 1 && bd == 0, "R3 write rnw/data", r * 10 + bd, 10);
    chk(ba == 0 && bus_addr == 3'd5, "R1 ext addr", int'(bus_addr), 5);
    chk(rsp_done === 1'b1, "R8 done after write", int'(rsp_done), 1);
    @(negedge clk);
    chk(rsp_done === 1'b0, "R8 done one cycle", int'(rsp_done), 0);
  endtask

  task automatic t_ext_read_intwait;
    int d, s, o, r, ba, bd;
    run_xfer(3'd2, 1'b0, 1'b1, 1'b1, 16'h0, 16'h1234, 0, d, s, o, r, ba, bd);
    chk(d == 2, "R5 internal wait length", d, 2);
    chk(s == 2, "R2 read strobe cycles", s, 2);
    chk(o == 0 && r == 0, "R3 R4 read no drive", o + r, 0);
    chk(rsp_rdata == 16'h1234, "R8 read data", int'(rsp_rdata), 32'h1234);
    chk(rsp_done === 1'b1, "R8 done after read", int'(rsp_done), 1);
    @(negedge clk);
    bus_din = 16'hFFFF;
    @(negedge clk);
    chk(rsp_rdata == 16'h1234, "R8 read data held", int'(rsp_rdata), 32'h1234);
  endtask

  task automatic t_ext_wait_pin;
    int d, s, o, r, ba, bd;
    run_xfer(3'd1, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0BEE, 2, d, s, o, r, ba, bd);
    chk(d == 3, "R6 wait pin two edges", d, 3);
    chk(s == 3, "R6 strobe spans waits", s, 3);
    chk(rsp_rdata == 16'h0BEE, "R8 read after waits", int'(rsp_rdata), 32'h0BEE);
    run_xfer(3'd6, 1'b1, 1'b1, 1'b1, 16'h7E81, 16'h0, 1, d, s, o, r, ba, bd);
    chk(d == 3, "R6 wait pin plus internal wait", d, 3);
    chk(o == 3 && bd == 0, "R4 doe over stretched write", o, 3);
  endtask

  task automatic t_internal;
    int d, s, o, r, ba, bd;
    run_xfer(3'd4, 1'b1, 1'b0, 1'b0, 16'h4242, 16'h0, 2, d, s, o, r, ba, bd);
    chk(d == 1, "R6 wait ignored internal", d, 1);
    chk(s == 0, "R2 no strobe internal", s, 0);
    chk(o == 0, "R4 no doe internal write", o, 0);
    chk(ba == 0 && bus_addr == 3'd4, "R1 internal addr", int'(bus_addr), 4);
    run_xfer(3'd3, 1'b0, 1'b0, 1'b1, 16'h0, 16'h5151, 0, d, s, o, r, ba, bd);
    chk(d == 2 && s == 0, "R5 internal read with wait bit", d * 10 + s, 20);
    chk(rsp_rdata == 16'h5151, "R8 internal read data", int'(rsp_rdata), 32'h5151);
  endtask

  task automatic t_reserved;
    @(negedge clk);
    req_valid = 1'b1; req_idx = 3'd7; req_write = 1'b1; req_ext = 1'b1;
    cfg_wait = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_err === 1'b1, "R7 err pulse", int'(rsp_err), 1);
    chk(busy === 1'b0 && bus_strobe_n === 1'b1, "R7 no transfer",
        int'(busy) * 10 + int'(bus_strobe_n), 1);
    chk(bus_addr == 3'd3, "R7 addr unchanged", int'(bus_addr), 3);
    chk(rsp_done === 1'b0, "R7 no done", int'(rsp_done), 0);
    @(negedge clk);
    chk(rsp_err === 1'b0, "R7 err one cycle", int'(rsp_err), 0);
  endtask

  task automatic t_busy_reject;
    @(negedge clk);
    req_valid = 1'b1; req_idx = 3'd1; req_write = 1'b0; req_ext = 1'b1;
    cfg_wait = 1'b1;
    @(negedge clk);
    req_idx = 3'd6;
    chk(busy === 1'b1, "R9 busy in transfer", int'(busy), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_addr == 3'd1, "R9 request ignored while busy", int'(bus_addr), 1);
    @(negedge clk);
    chk(busy === 1'b0, "R9 busy ends", int'(busy), 0);
  endtask

  task automatic t_port_mode;
    @(negedge clk);
    port_out_mode = 1'b1;
    #1;
    chk(bus_doe === 1'b1, "R4 port mode drives", int'(bus_doe), 1);
    chk(bus_strobe_n === 1'b1, "R2 port mode no strobe", int'(bus_strobe_n), 1);
    @(negedge clk);
    port_out_mode = 1'b0;
    #1;
    chk(bus_doe === 1'b0, "R4 port mode off", int'(bus_doe), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_idx = '0; req_write = 1'b0;
    req_ext = 1'b0; req_wdata = '0; cfg_wait = 1'b0; port_out_mode = 1'b0;
    bus_din = '0; bus_wait_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ext_write();
    t_ext_read_intwait();
    t_ext_wait_pin();
    t_internal();
    t_reserved();
    t_busy_reject();
    t_port_mode();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule